// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, for every incoming frame, whether the frame is accepted. The decision uses only the 48-bit destination address. The six destination bytes enter one per cycle. A start strobe marks the first byte. As the bytes arrive, the block compares them with the programmed station address, flags broadcast and multicast addresses, and builds a CRC-32 over them. The CRC chooses one of 64 hash bins.

Software programs the station address, two 32-bit hash registers and three mode bits through a write-only register port. One cycle after the sixth destination byte, the block pulses a decision strobe and presents the accept result. The accept result then holds until the next decision.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `accept` are 0 and every configuration register is zero.
- R2: A frame begins with a byte that has `byte_valid` and `frame_start` both high. Exactly six accepted bytes form the address. Bytes that arrive with `byte_valid` but without `frame_start`, while no frame is open (after reset or after the sixth byte), are ignored and produce no decision.
- R3: Register writes use `cfg_addr`. Address 1 bits 15:8 hold address byte 0 (the first byte received) and bits 7:0 hold byte 1. Address 0 bits 31:24, 23:16, 15:8 and 7:0 hold bytes 2, 3, 4 and 5. A unicast frame (byte 0 bit 0 clear) whose six bytes all equal these is accepted. A frame that differs in any byte is rejected unless another rule accepts it.
- R4: The hash index is bits 31:26 of a CRC-32 over the six bytes. The CRC is defined as follows: reflected polynomial 0xEDB88320, start value all ones, each byte least significant bit first, no final inversion. Index bit 5 selects the high hash register (address 3) when set and the low one (address 2) when clear. Index bits 4:0 give the bit within that register.
- R5: A multicast frame (byte 0 bit 0 set) that is not broadcast is accepted only when its hash bin is 1. With both hash registers all ones, every multicast frame is accepted.
- R6: A frame to FF:FF:FF:FF:FF:FF is rejected when mode bit 3 (address 4) is set and accepted when it is clear. The hash contents do not affect this.
- R7: When mode bit 5 is set, every frame is accepted.
- R8: When mode bit 4 is set, a unicast frame whose destination does not match the station address is still accepted if its hash bin is 1. When mode bit 4 is clear, such a frame is rejected.
- R9: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that captures the sixth byte. `accept` changes only when `dec_valid` rises, and it holds its value between decisions.
- R10: A byte with `frame_start` that arrives in the middle of an address discards the partial address and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0..4) |
| cfg_wdata | input | 32 | Register write data |
| byte_valid | input | 1 | A destination byte is present |
| frame_start | input | 1 | Marks the first destination byte |
| byte_data | input | 8 | Destination byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted (valid from the `dec_valid` cycle, held afterwards) |

## Verification
The hardest state to reach from the ports is a hash hit on a particular bin. The bin comes from a CRC, so no address can be chosen directly to land in a chosen bin. The bench therefore computes the CRC of each test address with its own bit-serial model and sets exactly that bin. It also sets the same bit position in the other hash register, and the neighbouring bin, to show that both the register select and the bit select are exact. Restarts in the middle of an address are driven by opening a frame, abandoning it after a few bytes and starting again. Trailing bytes sent after a decision confirm that no second decision appears.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam int MODE_BRO_BIT = 3;
   localparam int MODE_IAM_BIT = 4;
   localparam int MODE_PRO_BIT = 5;

   typedef struct packed {
      logic promisc;
      logic iam;
      logic bro_rej;
   } mode_t;

   typedef enum logic [2:0] {
      REG_STA_LO = 3'd0,
      REG_STA_HI = 3'd1,
      REG_HASH_LO = 3'd2,
      REG_HASH_HI = 3'd3,
      REG_MODE = 3'd4
   } reg_sel_e;

   // One byte through the reflected CRC, low bit first, no inversion.
   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'd0, d};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
   import rxaf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int NBYTES = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output logic [NBYTES*8-1:0]   station,
   output logic [2*DATA_W-1:0]   hash,
   output mode_t                 mode
);
   localparam int HI_BITS = NBYTES * 8 - DATA_W;

   logic [DATA_W-1:0]  sta_lo_q, hash_lo_q, hash_hi_q;
   logic [HI_BITS-1:0] sta_hi_q;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:HI_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_lo_q  <= '0;
         sta_hi_q  <= '0;
         hash_lo_q <= '0;
         hash_hi_q <= '0;
         mode      <= '0;
      end else if (cfg_wr) begin
         case (cfg_addr)
            ADDR_W'(REG_STA_LO):  sta_lo_q  <= cfg_wdata;
            ADDR_W'(REG_STA_HI):  sta_hi_q  <= cfg_wdata[HI_BITS-1:0];
            ADDR_W'(REG_HASH_LO): hash_lo_q <= cfg_wdata;
            ADDR_W'(REG_HASH_HI): hash_hi_q <= cfg_wdata;
            ADDR_W'(REG_MODE): begin
               mode.promisc <= cfg_wdata[MODE_PRO_BIT];
               mode.iam     <= cfg_wdata[MODE_IAM_BIT];
               mode.bro_rej <= cfg_wdata[MODE_BRO_BIT];
            end
            default: ;
         endcase
      end
   end

   // First received byte sits in the top byte of station.
   assign station = {sta_hi_q, sta_lo_q};
   assign hash    = {hash_hi_q, hash_lo_q};
endmodule

// File: rtl/rxaf_crc_acc.sv
module rxaf_crc_acc
   import rxaf_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic [7:0]       data,
   output logic [IDX_W-1:0] hash_idx
);
   logic [31:0] crc_q, crc_nxt;

   assign crc_nxt  = crc_byte(start ? 32'hFFFF_FFFF : crc_q, data);
   assign hash_idx = crc_nxt[31 -: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
      else if (en) crc_q <= crc_nxt;
   end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
   import rxaf_pkg::*;
#(
   parameter int NBYTES = 6,
   parameter int HASH_W = 64,
   parameter int IDX_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                byte_valid,
   input  logic                frame_start,
   input  logic [7:0]          byte_data,
   input  logic [NBYTES*8-1:0] station,
   input  logic [HASH_W-1:0]   hash,
   input  mode_t               mode,
   input  logic [IDX_W-1:0]    hash_idx,
   output logic                crc_en,
   output logic                crc_start,
   output logic                dec_valid,
   output logic                accept
);
   localparam int CNT_W = $clog2(NBYTES + 1);

   logic [CNT_W-1:0] cnt_q, idx;
   logic [7:0]       sta_b [NBYTES];
   logic [7:0]       sta_sel;
   logic             match_q, bcast_q, mcast_q;
   logic             match_n, bcast_n, mcast_n;
   logic             take, last, hit, verdict;

   for (genvar g = 0; g < NBYTES; g++) begin : g_sta
      assign sta_b[g] = station[(NBYTES-g)*8-1 -: 8];
   end

   assign idx  = frame_start ? '0 : cnt_q;
   assign take = byte_valid && (frame_start || (cnt_q != '0 && cnt_q < CNT_W'(NBYTES)));
   assign last = take && (idx == CNT_W'(NBYTES - 1));

   always_comb begin
      sta_sel = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (idx == CNT_W'(i)) sta_sel = sta_b[i];
      end
   end

   assign match_n = (frame_start | match_q) & (byte_data == sta_sel);
   assign bcast_n = (frame_start | bcast_q) & (byte_data == 8'hFF);
   assign mcast_n = frame_start ? byte_data[0] : mcast_q;
   assign hit     = hash[hash_idx];

   always_comb begin
      if (mode.promisc)  verdict = 1'b1;
      else if (bcast_n)  verdict = !mode.bro_rej;
      else if (mcast_n)  verdict = hit;
      else               verdict = match_n || (mode.iam && hit);
   end

   assign crc_en    = take;
   assign crc_start = byte_valid && frame_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         match_q   <= 1'b0;
         bcast_q   <= 1'b0;
         mcast_q   <= 1'b0;
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else begin
         dec_valid <= last;
         if (take) begin
            cnt_q   <= idx + 1'b1;
            match_q <= match_n;
            bcast_q <= bcast_n;
            mcast_q <= mcast_n;
         end
         if (last) accept <= verdict;
      end
   end

   // R9
   dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);
   // R2
   dec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(byte_valid));
   // R9
   accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> $stable(accept));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int NBYTES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              byte_valid,
   input  logic              frame_start,
   input  logic [7:0]        byte_data,
   output logic              dec_valid,
   output logic              accept
);
   localparam int HASH_W = 2 * DATA_W;
   localparam int IDX_W  = $clog2(HASH_W);

   if (NBYTES != 6) begin : g_bad_nbytes
      $error("rx_addr_filter: destination address must be six bytes");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("rx_addr_filter: register width must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("rx_addr_filter: register select needs at least 3 bits");
   end

   logic [NBYTES*8-1:0] station;
   logic [HASH_W-1:0]   hash;
   mode_t               mode;
   logic [IDX_W-1:0]    hash_idx;
   logic                crc_en, crc_start;

   rxaf_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .station(station), .hash(hash), .mode(mode));

   rxaf_crc_acc #(.IDX_W(IDX_W)) crc_i (
      .clk(clk), .rst_n(rst_n), .en(crc_en), .start(crc_start),
      .data(byte_data), .hash_idx(hash_idx));

   rxaf_decide #(.NBYTES(NBYTES), .HASH_W(HASH_W), .IDX_W(IDX_W)) dec_i (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_start(frame_start),
      .byte_data(byte_data), .station(station), .hash(hash), .mode(mode),
      .hash_idx(hash_idx), .crc_en(crc_en), .crc_start(crc_start),
      .dec_valid(dec_valid), .accept(accept));

   // R7
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (accept || !$past(mode.promisc)));
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        byte_valid = 1'b0;
   logic        frame_start = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        dec_valid, accept;

   int n_chk = 0;
   int n_fail = 0;

   // bench-side view of what was programmed
   logic [7:0]  m_sta [6];
   logic [63:0] m_hash;
   logic        m_pro, m_iam, m_bro;

   always #4 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .byte_valid(byte_valid), .frame_start(frame_start),
      .byte_data(byte_data), .dec_valid(dec_valid), .accept(accept));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] ref_idx(input logic [7:0] a [6]);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ a[i][k];
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [7:0] a [6]);
      logic bc = 1'b1, eq = 1'b1, hit;
      for (int i = 0; i < 6; i++) begin
         bc = bc & (a[i] == 8'hFF);
         eq = eq & (a[i] == m_sta[i]);
      end
      hit = m_hash[ref_idx(a)];
      if (m_pro) return 1'b1;
      if (bc) return !m_bro;
      if (a[0][0]) return hit;
      return eq || (m_iam && hit);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_station(input logic [7:0] a [6]);
      m_sta = a;
      wr(3'd1, {16'h0, a[0], a[1]});
      wr(3'd0, {a[2], a[3], a[4], a[5]});
   endtask

   task automatic set_hash(input logic [63:0] h);
      m_hash = h;
      wr(3'd2, h[31:0]);
      wr(3'd3, h[63:32]);
   endtask

   task automatic set_mode(input logic pro, input logic iam, input logic bro);
      m_pro = pro; m_iam = iam; m_bro = bro;
      wr(3'd4, {26'h0, pro, iam, bro, 3'b000});
   endtask

   // drive n bytes, the first with frame_start; checks no early decision
   task automatic drive_bytes(input logic [7:0] a [6], input int n, input string req);
      logic early = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i > 0 && dec_valid) early = 1'b1;
         byte_valid = 1'b1; frame_start = (i == 0); byte_data = a[i];
      end
      @(negedge clk);
      byte_valid = 1'b0; frame_start = 1'b0;
      chk({req, " no early decision"}, {31'h0, early}, 32'h0);
   endtask

   task automatic send_frame(input logic [7:0] a [6], input string req);
      logic exp;
      exp = ref_accept(a);
      drive_bytes(a, 6, req);
      chk({req, " R9 dec_valid pulse"}, {31'h0, dec_valid}, 32'h1);
      chk({req, " accept"}, {31'h0, accept}, {31'h0, exp});
      @(negedge clk);
      chk({req, " R9 dec_valid drops"}, {31'h0, dec_valid}, 32'h0);
      chk({req, " R9 accept holds"}, {31'h0, accept}, {31'h0, exp});
   endtask

   task automatic t_reset();
      chk("R1 dec_valid", {31'h0, dec_valid}, 32'h0);
      chk("R1 accept", {31'h0, accept}, 32'h0);
   endtask

   task automatic t_unicast();
      logic [7:0] st [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      logic [7:0] d5 [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56};
      logic [7:0] d0 [6] = '{8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      set_station(st);
      set_hash(64'h0);
      set_mode(1'b0, 1'b0, 1'b0);
      send_frame(st, "R3 station match");
      send_frame(d5, "R3 last byte differs");
      send_frame(d0, "R3 first byte differs");
      send_frame(st, "R3 match again");
   endtask

   task automatic t_multicast();
      logic [7:0] mc [6] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB};
      logic [5:0] ix;
      ix = ref_idx(mc);
      set_hash(64'h0);
      send_frame(mc, "R5 empty table rejects");
      set_hash(64'h1 << ix);
      send_frame(mc, "R4 exact bin");
      set_hash(64'h1 << {~ix[5], ix[4:0]});
      send_frame(mc, "R4 other register same bit");
      set_hash(64'h1 << {ix[5], ix[4:0] ^ 5'd1});
      send_frame(mc, "R4 neighbour bit");
      set_hash({64{1'b1}});
      send_frame(mc, "R5 all ones accepts");
   endtask

   task automatic t_broadcast();
      logic [7:0] bc [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      set_hash(64'h0);
      set_mode(1'b0, 1'b0, 1'b0);
      send_frame(bc, "R6 broadcast allowed");
      set_hash({64{1'b1}});
      set_mode(1'b0, 1'b0, 1'b1);
      send_frame(bc, "R6 broadcast rejected");
   endtask

   task automatic t_promisc();
      logic [7:0] uc [6] = '{8'hA8, 8'h9C, 8'h01, 8'h02, 8'h03, 8'h04};
      logic [7:0] bc [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      set_hash(64'h0);
      set_mode(1'b1, 1'b0, 1'b1);
      send_frame(uc, "R7 foreign unicast");
      send_frame(bc, "R7 broadcast with reject bit");
      set_mode(1'b0, 1'b0, 1'b1);
      send_frame(uc, "R7 off rejects");
   endtask

   task automatic t_iam();
      logic [7:0] uc [6] = '{8'h00, 8'h1B, 8'h21, 8'h3C, 8'h4D, 8'h7E};
      set_hash(64'h1 << ref_idx(uc));
      set_mode(1'b0, 1'b1, 1'b0);
      send_frame(uc, "R8 hash unicast accepted");
      set_mode(1'b0, 1'b0, 1'b0);
      send_frame(uc, "R8 mode off rejects");
   endtask

   task automatic t_restart();
      logic [7:0] junk [6] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
      set_hash(64'h0);
      set_mode(1'b0, 1'b0, 1'b0);
      drive_bytes(junk, 3, "R10 partial");
      chk("R10 no decision on partial", {31'h0, dec_valid}, 32'h0);
      send_frame(m_sta, "R10 restart");
   endtask

   task automatic t_ignored();
      logic [7:0] bc [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      logic seen = 1'b0;
      // accept is 1 from previous test; rejected broadcast would flip it
      set_mode(1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (dec_valid) seen = 1'b1;
         byte_valid = 1'b1; frame_start = 1'b0; byte_data = bc[i % 6];
      end
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
      byte_valid = 1'b0;
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
      chk("R2 stray bytes give no decision", {31'h0, seen}, 32'h0);
      chk("R2 stray bytes leave accept", {31'h0, accept}, 32'h1);
   endtask

   initial begin
      m_sta = '{default: 8'h00};
      m_hash = '0; m_pro = 0; m_iam = 0; m_bro = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unicast();
      t_multicast();
      t_broadcast();
      t_promisc();
      t_iam();
      t_restart();
      t_ignored();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule